// File: doc/BRIEF.md
# Integer Execute Unit with Compare-and-Set

This block is the integer execute stage of a small load/store processor. It takes two register operands and a 16-bit two's complement immediate, and an operation code picks the datapath that produces the result. The datapaths are modular add and subtract, bitwise logic, single-step logical shifts, an adder pass that forms load/store effective addresses, and a set-on-relation path. The set-on-relation path compares the first operand, read as a signed value, with the sign-extended immediate and returns 1 or 0. The add/subtract path also reports an overflow flag and a negative flag, and the negative flag gives the sign of the exact result.

Every path that needs the immediate uses it only after sign extension. The signed compare reuses the subtractor. Its "less than" decision is the true sign of the difference, which is the raw sign bit corrected by overflow. This keeps the compare correct even when the subtraction wraps. The output can go through an optional register that loads on a valid strobe. With the register in place, results appear one clock after the operation is presented.

Top module: `int_exec_unit`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the registered `result`, `ovf` and `neg` all become zero.
- R2: Op code 0 (add) yields `opa + opb` and op code 1 (sub) yields `opa - opb`, both taken modulo 2^W.
- R3: For op codes 0, 1, 7 and 9, `ovf` is 1 exactly when the exact signed sum or difference falls outside the signed W-bit range.
- R4: For op codes 0, 1, 7 and 9, `neg` is 1 exactly when the exact signed result, before wrapping, is below zero.
- R5: Op codes 2, 3 and 4 yield the bitwise AND, OR and XOR of `opa` and `opb`, with both flags 0.
- R6: Op code 5 shifts `opa` left by one and op code 6 shifts it right by one. The vacated bit is filled with 0, `opb` has no effect, and both flags are 0.
- R7: Op code 7 (add immediate) and op code 9 (effective address) both yield `opa` plus the IMM_W-bit immediate sign-extended to W bits, modulo 2^W.
- R8: Op code 8 (set-on-relation) yields 1 when the relation holds and 0 otherwise, with both flags 0. It compares signed `opa` against the sign-extended immediate, and `rel` selects the relation: 0 less, 1 equal, 2 greater, 3 less-or-equal, 4 greater-or-equal, 5 not-equal.
- R9: Op codes 10 to 15 yield a zero result with both flags 0. With op code 8, the `rel` values 6 and 7 also yield a zero result.
- R10: With the output register enabled, outputs reflect the operation presented at the previous rising edge where `in_valid` was high. They hold while `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Loads the output register |
| op | input | 4 | Operation code |
| rel | input | 3 | Relation code for set-on-relation |
| opa | input | W | First operand |
| opb | input | W | Second register operand |
| imm | input | IMM_W | Two's complement immediate |
| result | output | W | Operation result |
| ovf | output | 1 | Signed overflow of add/sub path |
| neg | output | 1 | True sign of exact add/sub result |

## Verification
The bench uses an 8-bit build with a 4-bit immediate. It sweeps every first operand against a spread of second operands and against every immediate, so each sign combination near the wrap point is covered. An unsigned or raw-sign compare would fail the less/greater relations where `opa - imm` overflows, and a `neg` taken from the wrapped sum would be wrong in those same cases. A missing sign extension would break add-immediate with negative immediates, and a shift that wraps the outgoing bit around would show up on operands whose high and low bits are set. The bench also checks the hold-while-idle behaviour, the rejected op and relation codes, and reset.

// File: rtl/exu_pkg.sv
// Shared encodings for the integer execute unit.
// Assumes op codes fit in 4 bits and relation codes in 3 bits.
package exu_pkg;
    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_ADDI = 4'd7,
        OP_SETI = 4'd8,
        OP_EA   = 4'd9
    } op_e;

    typedef enum logic [2:0] {
        REL_LT = 3'd0,
        REL_EQ = 3'd1,
        REL_GT = 3'd2,
        REL_LE = 3'd3,
        REL_GE = 3'd4,
        REL_NE = 3'd5
    } rel_e;
endpackage

// File: rtl/exu_addsub.sv
// Modular adder/subtractor with signed overflow and true-sign flags.
// Assumes operands are already width-matched; subtract is a + ~b + 1.
module exu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         neg
);
    logic [W-1:0] b_eff;

    // Invert the second operand for subtraction, carry-in supplies the +1.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
        neg   = sum[W-1] ^ ovf;
    end
endmodule

// File: rtl/exu_logic.sv
// Bitwise logic and single-position logical shifts.
// Assumes shifts always move by one and fill with zero; b is unused for shifts.
module exu_logic
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_e          op,
    output logic [W-1:0] res
);
    // Pick the logic or shift result; any other code gives zero.
    always_comb begin
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SLL:  res = {a[W-2:0], 1'b0};
            OP_SRL:  res = {1'b0, a[W-1:1]};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/exu_compare.sv
// Relation decoder for set-on-relation, driven by the subtractor.
// Assumes lt is the overflow-corrected sign of (a - imm) and diff is the wrapped difference.
module exu_compare
    import exu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   rel,
    input  logic [W-1:0] diff,
    input  logic         lt,
    output logic         hit
);
    logic eq;

    // Decode the selected relation from less-than and equality.
    always_comb begin
        eq = (diff == '0);
        case (rel_e'(rel))
            REL_LT:  hit = lt;
            REL_EQ:  hit = eq;
            REL_GT:  hit = !lt && !eq;
            REL_LE:  hit = lt || eq;
            REL_GE:  hit = !lt;
            REL_NE:  hit = !eq;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
// Integer execute unit: add/sub, logic, one-bit shifts, effective address
// and set-on-relation against a sign-extended immediate.
// Assumes W > IMM_W. With REGISTERED set, outputs load on in_valid and reset
// synchronously to zero; otherwise they follow the inputs combinationally.
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int W          = 32,
    parameter int IMM_W      = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [2:0]       rel,
    input  logic [W-1:0]     opa,
    input  logic [W-1:0]     opb,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     result,
    output logic             ovf,
    output logic             neg
);
    localparam int EXT_W = W - IMM_W;

    op_e          op_s;
    logic [W-1:0] imm_ext;
    logic         use_imm;
    logic         do_sub;
    logic [W-1:0] add_b;
    logic [W-1:0] sum;
    logic         add_ovf;
    logic         add_neg;
    logic [W-1:0] lg_res;
    logic         set_hit;
    logic [W-1:0] nxt_res;
    logic         nxt_ovf;
    logic         nxt_neg;

    // Decode operand source and adder direction.
    always_comb begin
        op_s    = op_e'(op);
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        use_imm = (op_s == OP_ADDI) || (op_s == OP_SETI) || (op_s == OP_EA);
        do_sub  = (op_s == OP_SUB) || (op_s == OP_SETI);
        add_b   = use_imm ? imm_ext : opb;
    end

    exu_addsub #(.W(W)) u_addsub (
        .a   (opa),
        .b   (add_b),
        .sub (do_sub),
        .sum (sum),
        .ovf (add_ovf),
        .neg (add_neg)
    );

    exu_logic #(.W(W)) u_logic (
        .a   (opa),
        .b   (opb),
        .op  (op_s),
        .res (lg_res)
    );

    exu_compare #(.W(W)) u_cmp (
        .rel  (rel),
        .diff (sum),
        .lt   (add_neg),
        .hit  (set_hit)
    );

    // Select the result and flags for the current operation.
    always_comb begin
        nxt_res = '0;
        nxt_ovf = 1'b0;
        nxt_neg = 1'b0;
        case (op_s)
            OP_ADD, OP_SUB, OP_ADDI, OP_EA: begin
                nxt_res = sum;
                nxt_ovf = add_ovf;
                nxt_neg = add_neg;
            end
            OP_AND, OP_OR, OP_XOR, OP_SLL, OP_SRL: nxt_res = lg_res;
            OP_SETI: nxt_res = {{(W-1){1'b0}}, set_hit};
            default: nxt_res = '0;
        endcase
    end

    generate
        if (REGISTERED) begin : g_reg
            // Output register: synchronous active-low reset, load on valid.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    result <= '0;
                    ovf    <= 1'b0;
                    neg    <= 1'b0;
                end else if (in_valid) begin
                    result <= nxt_res;
                    ovf    <= nxt_ovf;
                    neg    <= nxt_neg;
                end
            end
        end else begin : g_comb
            assign result = nxt_res;
            assign ovf    = nxt_ovf;
            assign neg    = nxt_neg;
        end
    endgenerate
endmodule

// Property checker for int_exec_unit, attached by bind.
// Assumes the port names of the unit; registered build checks next-cycle outputs.
module int_exec_unit_chk #(
    parameter int W          = 32,
    parameter int IMM_W      = 16,
    parameter bit REGISTERED = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic [2:0]       rel,
    input logic [W-1:0]     opa,
    input logic [W-1:0]     opb,
    input logic [IMM_W-1:0] imm,
    input logic [W-1:0]     result,
    input logic             ovf,
    input logic             neg
);
    generate
        if (REGISTERED) begin : g_reg_chk
            logic prev_low = 1'b0;

            // Remember whether reset was low at the previous edge.
            always @(posedge clk) begin
                if (prev_low) begin
                    p_reset_clear_r1: assert (result == '0 && !ovf && !neg);
                end
                prev_low <= !rst_n;
            end

            p_add_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd0 && opb == '0) |=> (result == $past(opa) && !ovf));
            p_mixed_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd0 && opa[W-1] != opb[W-1]) |=> !ovf);
            p_logic_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op >= 4'd2 && op <= 4'd6) |=> (!ovf && !neg));
            p_sll_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd5) |=> !result[0]);
            p_srl_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd6) |=> !result[W-1]);
            p_addi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd7 && imm == '0) |=> (result == $past(opa) && !ovf));
            p_set_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd8) |=> (result[W-1:1] == '0 && !ovf && !neg));
            p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op >= 4'd10) |=> (result == '0 && !ovf && !neg));
            p_bad_rel_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd8 && rel >= 3'd6) |=> (result == '0));
            p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> $stable(result) && $stable(ovf) && $stable(neg));
        end else begin : g_comb_chk
            p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (op >= 4'd10) |-> (result == '0 && !ovf && !neg));
            p_set_bool_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (op == 4'd8) |-> (result[W-1:1] == '0));
            p_addi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (op == 4'd7 && imm == '0) |-> (result == opa));
            p_mixed_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 4'd0 && opa[W-1] != opb[W-1] && rel == 3'd0) |-> !ovf);
        end
    endgenerate
endmodule

bind int_exec_unit int_exec_unit_chk #(.W(W), .IMM_W(IMM_W), .REGISTERED(REGISTERED)) u_chk (.*);

// File: tb/int_exec_unit_tb.sv
module int_exec_unit_tb;
    localparam int W  = 8;
    localparam int IW = 4;
    localparam int MASK = (1 << W) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [3:0]    op = '0;
    logic [2:0]    rel = '0;
    logic [W-1:0]  opa = '0;
    logic [W-1:0]  opb = '0;
    logic [IW-1:0] imm = '0;
    logic [W-1:0]  result;
    logic          ovf;
    logic          neg;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    int_exec_unit #(.W(W), .IMM_W(IW), .REGISTERED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .rel(rel),
        .opa(opa), .opb(opb), .imm(imm), .result(result), .ovf(ovf), .neg(neg)
    );

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    task automatic check(input int er, input bit eo, input bit en, input string tag);
        n_vec++;
        if (result !== er[W-1:0] || ovf !== eo || neg !== en) begin
            n_bad++;
            $display("FAIL %s: got res=%0d ovf=%0b neg=%0b, expected res=%0d ovf=%0b neg=%0b",
                     tag, result, ovf, neg, er & MASK, eo, en);
        end
    endtask

    // Drive one operation at a falling edge; it is latched at the next rising edge.
    task automatic run(input int o, input int r, input int a, input int b, input int im,
                       input int er, input bit eo, input bit en, input string tag);
        op = o[3:0]; rel = r[2:0]; opa = a[W-1:0]; opb = b[W-1:0]; imm = im[IW-1:0];
        in_valid = 1'b1;
        @(negedge clk);
        check(er, eo, en, tag);
    endtask

    task automatic arith(input int o, input int a, input int bs, input string tag);
        int ex;
        ex = (o == 1) ? sx(a, W) - bs : sx(a, W) + bs;
        run(o, 0, a, (o == 7 || o == 9) ? 0 : bs & MASK, (o == 7 || o == 9) ? bs & ((1 << IW) - 1) : 0,
            ex & MASK, (ex > (1 << (W - 1)) - 1) || (ex < -(1 << (W - 1))), ex < 0, tag);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL R10: watchdog expired, got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        int last;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(0, 1'b0, 1'b0, "R1 reset");
        rst_n = 1'b1;
        @(negedge clk);

        for (int a = 0; a < 256; a++) begin
            for (int k = 0; k < 16; k++) begin
                int b;
                b = (k * 17 + 3) & MASK;
                arith(0, a, sx(b, W), "R2 R3 R4 add");
                arith(1, a, sx(b, W), "R2 R3 R4 sub");
                run(2, 0, a, b, 0, a & b, 1'b0, 1'b0, "R5 and");
                run(3, 0, a, b, 0, a | b, 1'b0, 1'b0, "R5 or");
                run(4, 0, a, b, 0, a ^ b, 1'b0, 1'b0, "R5 xor");
            end
            // R6: shifts, opb set to a changing value that must not matter
            run(5, 0, a, a ^ 8'h5a, 0, (a << 1) & MASK, 1'b0, 1'b0, "R6 sll");
            run(6, 0, a, ~a, 0, a >> 1, 1'b0, 1'b0, "R6 srl");
            for (int im = 0; im < (1 << IW); im++) begin
                arith(7, a, sx(im, IW), "R7 R3 R4 addi");
                arith(9, a, sx(im, IW), "R7 ea");
                for (int r = 0; r < 8; r++) begin
                    int sa, si;
                    bit h;
                    sa = sx(a, W); si = sx(im, IW);
                    case (r)
                        0: h = sa < si;
                        1: h = sa == si;
                        2: h = sa > si;
                        3: h = sa <= si;
                        4: h = sa >= si;
                        5: h = sa != si;
                        default: h = 1'b0;
                    endcase
                    run(8, r, a, 8'h33, im, int'(h), 1'b0, 1'b0, r > 5 ? "R9 bad rel" : "R8 set");
                end
            end
        end

        // R9: unsupported op codes
        for (int o = 10; o < 16; o++) run(o, 0, 8'h80, 8'h80, 4'h8, 0, 1'b0, 1'b0, "R9 bad op");

        // R10: hold while in_valid low
        run(0, 0, 8'h7f, 8'h01, 0, 8'h80, 1'b1, 1'b0, "R10 load");
        last = 8'h80;
        in_valid = 1'b0;
        op = 4'd2; opa = 8'h0f; opb = 8'hf0;
        repeat (3) @(negedge clk);
        check(last, 1'b1, 1'b0, "R10 hold");

        // R1: synchronous reset after a nonzero result
        rst_n = 1'b0;
        @(negedge clk);
        check(0, 1'b0, 1'b0, "R1 reset mid-run");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule